// File: doc/BRIEF.md
# Dual-Channel Bus-Master Register File

This block holds the software-visible control state of a two-channel bus-master disk controller. A host reaches it through a sixteen-port I/O window. One address bit picks the channel and the three low bits pick a register inside that channel. Each channel has three registers:

- a command register, which carries the run/stop control and the transfer direction;
- a status register, which mixes bits the engine drives, bits software may write, and sticky flags that software clears by writing ones;
- a 32-bit descriptor table pointer, loaded a byte at a time or with wider accesses.

The block passes run, direction and table pointer straight to a DMA engine for each channel. It takes back single-cycle completion, error and interrupt pulses from that engine.

Accesses are one, two or four bytes wide. A wide access covers consecutive offsets starting at the addressed one. Read data comes back registered, one cycle after the read strobe.

Top module: `busmaster_regs`

## Requirements
- R1: `ioAddr[3]` selects the channel (0 or 1) and `ioAddr[2:0]` gives the starting offset. Offset 0 is command, offset 2 is status, and offsets 4..7 hold pointer bytes 0..3 (least significant first). `ioSize` encodes width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Code 3 is reserved: it writes nothing and reads as zero.
- R2: Any non-reserved write that covers offset 0 stores data bit 0 as the run control and data bit 3 as the direction. These appear on `engStart`/`engDir` one cycle after the write. All other command bits read as zero.
- R3: A command write that takes run from 0 to 1 sets status bit 0 (active). A command write with bit 0 clear clears active.
- R4: Status is written only by a 1-byte write at offset 2. A wider access that covers offset 2 leaves status unchanged.
- R5: On a status write, bits 6:5 take the written value and bit 0 keeps its value. Bits 1 and 2 are cleared where the written byte holds a one and kept otherwise. Bits 7, 4 and 3 always read as zero.
- R6: A completion pulse clears active and sets bit 2. An interrupt pulse sets bit 2. An error pulse sets bit 1. In the same cycle, a set beats a software clear, and a run 0-to-1 write beats a completion.
- R7: Each pointer byte whose offset lies inside a non-reserved write takes the data byte at (offset − start offset). `engTablePtr` shows the result one cycle later, with bits 31:0 for channel 0 and bits 63:32 for channel 1.
- R8: A read returns data on `ioRdData` one cycle after `ioRd`. Data byte b holds register offset (start + b) for each byte inside the access width. Offsets 1, 3 and those past 7 read as zero, and unused upper bytes read as zero. `ioRdData` holds its value while no read is issued.
- R9: An access to one channel never changes the other channel's registers or engine outputs.
- R10: Reset clears every register in both channels, the engine outputs and `ioRdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | 4 | Channel bit and register offset |
| ioSize | input | 2 | Access width code |
| ioWr | input | 1 | Write strobe |
| ioRd | input | 1 | Read strobe |
| ioWrData | input | 32 | Write data, byte 0 at the start offset |
| ioRdData | output | 32 | Registered read data |
| engStart | output | 2 | Run control per channel |
| engDir | output | 2 | Direction control per channel |
| engTablePtr | output | 64 | Descriptor table pointer per channel |
| engDone | input | 2 | Completion pulse per channel |
| engErr | input | 2 | Error pulse per channel |
| engIrq | input | 2 | Interrupt pulse per channel |

## Verification
Writes and engine pulses update the registers on the clock edge that samples them, so engine outputs are due one edge after the stimulus. Read data is due one edge after `ioRd` is sampled. The bench drives every stimulus at a falling edge and samples at the next falling edge, which puts each check exactly one register stage after its cause. Status effects are not visible directly on the pins, so the bench observes them with a read issued after the write or pulse has settled. An exhaustive sweep covers every offset and width in both channels, comparing the outputs against an arithmetic model of the lane mapping and status rules.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  localparam int NUM_CH    = 2;
  localparam int CH_W      = 1;
  localparam int OFF_W     = 3;
  localparam int ADDR_W    = OFF_W + CH_W;
  localparam int DATA_W    = 32;
  localparam int PTR_BYTES = 4;
  localparam int PTR_W     = PTR_BYTES * 8;
  localparam int VIEW_W    = (1 << OFF_W) * 8;
  localparam int LANES     = DATA_W / 8;

  localparam int OFF_CMD  = 0;
  localparam int OFF_STAT = 2;
  localparam int OFF_PTR  = 4;

  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 3;
  localparam int ST_ACT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_IRQ  = 2;
  localparam int ST_CAP  = 5;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } accSize_e;

  typedef struct packed {
    logic [CH_W-1:0]                ch;
    logic                           cmdWr;
    logic                           statWr;
    logic [PTR_BYTES-1:0]           ptrWr;
    logic [PTR_BYTES-1:0][1:0]      ptrSrc;
    logic                           rdEn;
    logic [OFF_W-1:0]               off;
    logic [LANES-1:0]               laneMask;
  } strobes_t;
endpackage

// File: rtl/bmr_ctrl.sv
module bmr_ctrl
  import bmr_pkg::*;
(
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [1:0]        ioSize,
  input  logic              ioWr,
  input  logic              ioRd,
  output strobes_t          stb
);
  logic [OFF_W-1:0] off;
  logic             sizeOk;
  logic [2:0]       nBytes;
  logic [OFF_W:0]   endOff;

  assign off    = ioAddr[OFF_W-1:0];
  assign sizeOk = (accSize_e'(ioSize) != SZ_RSVD);

  always_comb begin
    case (accSize_e'(ioSize))
      SZ_BYTE:  nBytes = 3'd1;
      SZ_WORD:  nBytes = 3'd2;
      SZ_DWORD: nBytes = 3'd4;
      default:  nBytes = 3'd0;
    endcase
  end

  assign endOff = {1'b0, off} + {1'b0, nBytes};

  always_comb begin
    logic [OFF_W:0] pos;
    stb          = '0;
    stb.ch       = ioAddr[OFF_W +: CH_W];
    stb.off      = off;
    stb.rdEn     = ioRd;
    stb.cmdWr    = ioWr && sizeOk && (off == OFF_W'(OFF_CMD));
    stb.statWr   = ioWr && (accSize_e'(ioSize) == SZ_BYTE) && (off == OFF_W'(OFF_STAT));
    for (int b = 0; b < LANES; b++) begin
      stb.laneMask[b] = sizeOk && (b < int'(nBytes));
    end
    for (int k = 0; k < PTR_BYTES; k++) begin
      pos            = (OFF_W+1)'(OFF_PTR + k);
      stb.ptrWr[k]   = ioWr && sizeOk && ({1'b0, off} <= pos) && (pos < endOff);
      stb.ptrSrc[k]  = 2'(pos - {1'b0, off});
    end
  end
endmodule

// File: rtl/bmr_datapath.sv
module bmr_datapath
  import bmr_pkg::*;
#(
  parameter int CHANNELS = NUM_CH
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobes_t                   stb,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [CHANNELS-1:0]        engDone,
  input  logic [CHANNELS-1:0]        engErr,
  input  logic [CHANNELS-1:0]        engIrq,
  output logic [CHANNELS-1:0]        engStart,
  output logic [CHANNELS-1:0]        engDir,
  output logic [CHANNELS*PTR_W-1:0]  engTablePtr,
  output logic [DATA_W-1:0]          rdData
);
  logic [CHANNELS-1:0][VIEW_W-1:0] view;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    logic             run, dir, act, err, irq;
    logic [1:0]       cap;
    logic [PTR_W-1:0] ptr;
    logic             hit;
    logic [7:0]       cmdByte, statByte;

    assign hit = (stb.ch == CH_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        run <= 1'b0;
        dir <= 1'b0;
        act <= 1'b0;
        err <= 1'b0;
        irq <= 1'b0;
        cap <= 2'b00;
        ptr <= '0;
      end else begin
        if (hit && stb.cmdWr) begin
          run <= wrData[CMD_RUN];
          dir <= wrData[CMD_DIR];
        end
        if (hit && stb.cmdWr && wrData[CMD_RUN] && !run) act <= 1'b1;
        else if (hit && stb.cmdWr && !wrData[CMD_RUN])  act <= 1'b0;
        else if (engDone[c])                            act <= 1'b0;

        if (engErr[c])                                  err <= 1'b1;
        else if (hit && stb.statWr && wrData[ST_ERR])   err <= 1'b0;

        if (engDone[c] || engIrq[c])                    irq <= 1'b1;
        else if (hit && stb.statWr && wrData[ST_IRQ])   irq <= 1'b0;

        if (hit && stb.statWr) cap <= wrData[ST_CAP +: 2];

        for (int k = 0; k < PTR_BYTES; k++) begin
          if (hit && stb.ptrWr[k]) ptr[8*k +: 8] <= wrData[8*stb.ptrSrc[k] +: 8];
        end
      end
    end

    always_comb begin
      cmdByte          = '0;
      cmdByte[CMD_RUN] = run;
      cmdByte[CMD_DIR] = dir;
      statByte                = '0;
      statByte[ST_ACT]        = act;
      statByte[ST_ERR]        = err;
      statByte[ST_IRQ]        = irq;
      statByte[ST_CAP +: 2]   = cap;
    end

    assign view[c] = {ptr, 8'h00, statByte, 8'h00, cmdByte};
    assign engStart[c] = run;
    assign engDir[c]   = dir;
    assign engTablePtr[c*PTR_W +: PTR_W] = ptr;
  end

  logic [VIEW_W-1:0] selView;
  logic [DATA_W-1:0] rdNext;

  assign selView = view[stb.ch];

  always_comb begin
    rdNext = '0;
    for (int b = 0; b < LANES; b++) begin
      if (stb.laneMask[b] && (int'(stb.off) + b) < (1 << OFF_W))
        rdNext[8*b +: 8] = selView[8*(int'(stb.off) + b) +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rdData <= '0;
    else if (stb.rdEn) rdData <= rdNext;
  end
endmodule

// File: rtl/busmaster_regs.sv
module busmaster_regs
  import bmr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        ioAddr,
  input  logic [1:0]               ioSize,
  input  logic                     ioWr,
  input  logic                     ioRd,
  input  logic [DATA_W-1:0]        ioWrData,
  output logic [DATA_W-1:0]        ioRdData,
  output logic [NUM_CH-1:0]        engStart,
  output logic [NUM_CH-1:0]        engDir,
  output logic [NUM_CH*PTR_W-1:0]  engTablePtr,
  input  logic [NUM_CH-1:0]        engDone,
  input  logic [NUM_CH-1:0]        engErr,
  input  logic [NUM_CH-1:0]        engIrq
);
  strobes_t stb;

  bmr_ctrl u_ctrl (
    .ioAddr (ioAddr),
    .ioSize (ioSize),
    .ioWr   (ioWr),
    .ioRd   (ioRd),
    .stb    (stb)
  );

  bmr_datapath #(.CHANNELS(NUM_CH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrData      (ioWrData),
    .engDone     (engDone),
    .engErr      (engErr),
    .engIrq      (engIrq),
    .engStart    (engStart),
    .engDir      (engDir),
    .engTablePtr (engTablePtr),
    .rdData      (ioRdData)
  );
endmodule

// File: rtl/bmr_checker.sv
module bmr_checker (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  ioAddr,
  input logic [1:0]  ioSize,
  input logic        ioWr,
  input logic        ioRd,
  input logic [31:0] ioWrData,
  input logic [31:0] ioRdData,
  input logic [1:0]  engStart,
  input logic [1:0]  engDir,
  input logic [63:0] engTablePtr,
  input logic [1:0]  engDone,
  input logic [1:0]  engErr,
  input logic [1:0]  engIrq
);
  p_rsvd_size_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioSize == 2'd3) |=> ($stable(engStart) && $stable(engDir) && $stable(engTablePtr)));

  p_cmd_fields_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioSize != 2'd3 && ioAddr == 4'h0) |=>
      (engStart[0] == $past(ioWrData[0]) && engDir[0] == $past(ioWrData[3])));

  p_ptr_byte_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioSize == 2'd0 && ioAddr == 4'hC) |=> (engTablePtr[39:32] == $past(ioWrData[7:0])));

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ioRd |=> $stable(ioRdData));

  p_ch_isolation_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ioAddr[3] == 1'b0) |=> ($stable(engStart[1]) && $stable(engDir[1]) && $stable(engTablePtr[63:32])));

  p_reset_clear_r10: assert property (@(posedge clk)
    !rstN |=> (engStart == 2'b00 && engDir == 2'b00 && engTablePtr == 64'h0 && ioRdData == 32'h0));
endmodule

bind busmaster_regs bmr_checker u_chk (.*);

// File: tb/sim_busmaster_regs.sv
module sim_busmaster_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  ioAddr = '0;
  logic [1:0]  ioSize = '0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [31:0] ioWrData = '0;
  logic [31:0] ioRdData;
  logic [1:0]  engStart, engDir;
  logic [63:0] engTablePtr;
  logic [1:0]  engDone = '0, engErr = '0, engIrq = '0;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  busmaster_regs u0 (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioSize(ioSize), .ioWr(ioWr), .ioRd(ioRd),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .engStart(engStart), .engDir(engDir),
    .engTablePtr(engTablePtr), .engDone(engDone), .engErr(engErr), .engIrq(engIrq)
  );

  logic        mStart[2], mDir[2], mAct[2], mErr[2], mIrq[2];
  logic [1:0]  mCap[2];
  logic [31:0] mPtr[2];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int c = 0; c < 2; c++) begin
      mStart[c] = 0; mDir[c] = 0; mAct[c] = 0; mErr[c] = 0; mIrq[c] = 0;
      mCap[c] = 0; mPtr[c] = 0;
    end
  endtask

  task automatic modelWrite(input int ch, input int off, input int sz,
                            input logic [31:0] d, output bit rose);
    int n;
    logic [7:0] byt;
    rose = 0;
    if (sz == 3) return;
    n = 1 << sz;
    for (int b = 0; b < n; b++) begin
      int o = off + b;
      if (o < 8) begin
        byt = d[8*b +: 8];
        if (o == 0) begin
          if (byt[0] && !mStart[ch]) begin mAct[ch] = 1; rose = 1; end
          else if (!byt[0]) mAct[ch] = 0;
          mStart[ch] = byt[0];
          mDir[ch] = byt[3];
        end
        if (o == 2 && n == 1) begin
          mCap[ch] = byt[6:5];
          if (byt[1]) mErr[ch] = 0;
          if (byt[2]) mIrq[ch] = 0;
        end
        if (o >= 4) mPtr[ch][8*(o-4) +: 8] = byt;
      end
    end
  endtask

  task automatic modelEvent(input int ch, input logic dn, input logic er, input logic iq, input bit rose);
    if (er) mErr[ch] = 1;
    if (dn || iq) mIrq[ch] = 1;
    if (dn && !rose) mAct[ch] = 0;
  endtask

  function automatic logic [31:0] expRead(input int ch, input int off, input int sz);
    logic [7:0]  v[8];
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) v[i] = 8'h00;
    v[0] = {4'b0, mDir[ch], 2'b0, mStart[ch]};
    v[2] = {1'b0, mCap[ch], 2'b0, mIrq[ch], mErr[ch], mAct[ch]};
    for (int k = 0; k < 4; k++) v[4+k] = mPtr[ch][8*k +: 8];
    if (sz == 3) return r;
    for (int b = 0; b < (1 << sz); b++)
      if (off + b < 8) r[8*b +: 8] = v[off+b];
    return r;
  endfunction

  task automatic access(input int ch, input int off, input int sz, input logic [31:0] d,
                        input logic [1:0] dn, input logic [1:0] er, input logic [1:0] iq);
    @(negedge clk);
    ioAddr = 4'(ch * 8 + off); ioSize = 2'(sz); ioWrData = d; ioWr = 1'b1;
    engDone = dn; engErr = er; engIrq = iq;
    @(negedge clk);
    ioWr = 1'b0; engDone = '0; engErr = '0; engIrq = '0;
    for (int c = 0; c < 2; c++) begin
      bit rose = 0;
      if (c == ch) modelWrite(c, off, sz, d, rose);
      modelEvent(c, dn[c], er[c], iq[c], rose);
    end
  endtask

  task automatic wr(input int ch, input int off, input int sz, input logic [31:0] d);
    access(ch, off, sz, d, 2'b00, 2'b00, 2'b00);
  endtask

  task automatic pulse(input int ch, input logic dn, input logic er, input logic iq);
    @(negedge clk);
    engDone[ch] = dn; engErr[ch] = er; engIrq[ch] = iq;
    @(negedge clk);
    engDone = '0; engErr = '0; engIrq = '0;
    modelEvent(ch, dn, er, iq, 0);
  endtask

  task automatic rd(input int ch, input int off, input int sz, output logic [31:0] v);
    @(negedge clk);
    ioAddr = 4'(ch * 8 + off); ioSize = 2'(sz); ioRd = 1'b1;
    @(negedge clk);
    ioRd = 1'b0;
    v = ioRdData;
  endtask

  task automatic chkRead(input string tag, input int ch, input int off, input int sz);
    logic [31:0] v;
    rd(ch, off, sz, v);
    chk(tag, v, expRead(ch, off, sz));
  endtask

  task automatic chkEng(input string tag);
    for (int c = 0; c < 2; c++) begin
      chk({tag, " engStart"}, 32'(engStart[c]), 32'(mStart[c]));
      chk({tag, " engDir"}, 32'(engDir[c]), 32'(mDir[c]));
      chk({tag, " engTablePtr"}, engTablePtr[c*32 +: 32], mPtr[c]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    modelReset();
    repeat (3) @(negedge clk);
    // R10: outputs cleared while in reset
    chk("R10 reset engStart", 32'(engStart), 0);
    chk("R10 reset ptr", engTablePtr[31:0], 0);
    chk("R10 reset ptr hi", engTablePtr[63:32], 0);
    chk("R10 reset rd", ioRdData, 0);
    rstN = 1'b1;
    for (int c = 0; c < 2; c++)
      for (int o = 0; o < 8; o++) chkRead("R10 post-reset read", c, o, 0);

    // R2 command fields, other bits read zero
    wr(0, 0, 0, 32'h09); chkEng("R2");
    chkRead("R2 cmd read", 0, 0, 0);
    wr(0, 0, 0, 32'hFF); chkRead("R2 cmd spare bits zero", 0, 0, 0);
    // R3 active follows run control
    chkRead("R3 active after start", 0, 2, 0);
    wr(0, 0, 0, 32'h00); chkRead("R3 active after stop", 0, 2, 0);
    wr(0, 0, 0, 32'h01); chkRead("R3 active rise", 0, 2, 0);
    wr(0, 0, 0, 32'h01); chkRead("R3 active steady", 0, 2, 0);
    // R4 status width rule
    wr(0, 2, 1, 32'h0060); chkRead("R4 word status ignored", 0, 2, 0);
    wr(0, 2, 2, 32'h0060); chkRead("R4 dword status ignored", 0, 2, 0);
    wr(0, 0, 2, 32'h0060_0000); chkRead("R4 dword over status", 0, 2, 0);
    // R6 events
    pulse(0, 1, 0, 0); chkRead("R6 completion", 0, 2, 0);
    pulse(0, 0, 1, 0); chkRead("R6 error", 0, 2, 0);
    pulse(1, 0, 0, 1); chkRead("R6 irq ch1", 1, 2, 0); chkRead("R9 ch0 untouched", 0, 2, 0);
    // R5 status write rules
    wr(0, 2, 0, 32'h64); chkRead("R5 cap set irq cleared", 0, 2, 0);
    wr(0, 2, 0, 32'hFF); chkRead("R5 all ones", 0, 2, 0);
    wr(0, 0, 0, 32'h00); wr(0, 0, 0, 32'h01);
    wr(0, 2, 0, 32'h00); chkRead("R5 active kept", 0, 2, 0);
    // R6 priorities
    wr(0, 0, 0, 32'h00);
    access(0, 0, 0, 32'h01, 2'b01, 2'b00, 2'b00); chkRead("R6 start beats done", 0, 2, 0);
    access(0, 2, 0, 32'h06, 2'b00, 2'b01, 2'b01); chkRead("R6 set beats clear", 0, 2, 0);
    // R7 pointer lanes
    wr(1, 4, 0, 32'hA1); wr(1, 5, 0, 32'hB2); wr(1, 6, 0, 32'hC3); wr(1, 7, 0, 32'hD4);
    chkEng("R7 bytes");
    wr(1, 4, 2, 32'h1234_5678); chkEng("R7 dword");
    wr(1, 6, 1, 32'h0000_9ABC); chkEng("R7 word high");
    wr(1, 6, 2, 32'hFFEE_DDCC); chkEng("R7 dword clipped");
    wr(0, 2, 2, 32'h5566_7788); chkEng("R7 dword from 2"); chkRead("R4 status unchanged", 0, 2, 0);
    // R8 reads
    chkRead("R8 ptr dword", 1, 4, 2); chkRead("R8 ptr word", 1, 5, 1);
    chkRead("R8 offset 1", 0, 1, 0); chkRead("R8 offset 3", 0, 3, 0);
    chkRead("R8 past end", 1, 6, 2); chkRead("R8 reserved read", 1, 4, 3);
    rd(1, 4, 2, v);
    repeat (3) @(negedge clk);
    chk("R8 hold", ioRdData, v);
    // R1 reserved size write
    wr(1, 4, 3, 32'h0BAD_F00D); wr(1, 0, 3, 32'h09); chkEng("R1 reserved write");
    chkRead("R1 reserved read back", 1, 4, 2);

    // Exhaustive sweep: R1 R7 R8 R9
    for (int c = 0; c < 2; c++)
      for (int o = 0; o < 8; o++)
        for (int s = 0; s < 4; s++) begin
          logic [31:0] d = 32'h9E37_79B9 * 32'(c * 32 + o * 4 + s + 1);
          wr(c, o, s, d);
          chkEng("R9 sweep");
          for (int ro = 0; ro < 8; ro++)
            for (int rs = 0; rs < 4; rs++) begin
              chkRead("R8 sweep ch0", 0, ro, rs);
              chkRead("R8 sweep ch1", 1, ro, rs);
            end
        end

    // R10 mid-run reset
    wr(0, 0, 0, 32'h09); wr(1, 4, 2, 32'hCAFE_F00D); pulse(1, 0, 1, 1);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    modelReset();
    chkEng("R10 mid reset");
    chk("R10 mid reset rd", ioRdData, 0);
    rstN = 1'b1;
    for (int c = 0; c < 2; c++)
      for (int o = 0; o < 8; o++) chkRead("R10 after mid reset", c, o, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule